// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block keeps the per-vector state of a local interrupt controller. It holds three bitmaps: requests waiting for service, vectors in service, and the trigger mode of each vector. A requester hands it a vector and a trigger mode. The block records the request, unless the vector is already pending, in which case it reports a duplicate. It works out a processor priority from a programmable task priority and the highest vector in service. It shows the processor the highest pending vector whenever that vector's 16-vector class beats the processor priority.

When the processor takes the offered vector (acknowledge), the vector moves from pending to in service. An end-of-interrupt strobe retires the highest vector in service. On the following cycle the block tells an external router which vector was retired and whether it was edge or level triggered. It does not send this message when directed EOI is enabled.

Top module: `vec_prio_arbiter`

## Requirements
- R1: After reset the processor priority is 0, no vector is offered and no EOI message is output.
- R2: An accepted request sets that vector's pending bit. While deliverable, `deliv_vec` is the highest-numbered pending vector.
- R3: `acc_taken` is 1 when the request is recorded as new. It is 0 when the vector was already pending, which is the duplicate case.
- R4: The controller is enabled only while both `hw_en` and `sw_en` are 1. While it is disabled, requests are dropped (`acc_taken` 0, no pending bit set) and `deliv_valid` is 0.
- R5: The processor priority equals the task priority when the task priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that vector with bits 3:0 cleared. When nothing is in service, the in-service vector counts as 0.
- R6: A pending vector is offered only when its class value (vector with bits 3:0 cleared) is strictly greater than the processor priority.
- R7: An acknowledge while a vector is offered clears that vector's pending bit and sets its in-service bit. An acknowledge while no vector is offered has no effect.
- R8: An EOI clears the highest in-service bit. On the next cycle `eoi_out_valid` pulses with that vector on `eoi_out_vec`.
- R9: Each accepted request writes its vector's trigger bit, 1 for level and 0 for edge, even when the request is a duplicate. An EOI reports that bit on `eoi_out_level` and then clears it.
- R10: An EOI while nothing is in service changes no state and sends no message.
- R11: While `dir_eoi_en` is 1, an EOI still retires the vector but `eoi_out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| dir_eoi_en | input | 1 | Directed EOI: suppresses the EOI message |
| acc_valid | input | 1 | Request strobe |
| acc_vec | input | 8 | Requested vector |
| acc_level | input | 1 | 1 for level trigger, 0 for edge trigger |
| acc_taken | output | 1 | Request recorded as new (combinational) |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| ack_strobe | input | 1 | Processor takes the offered vector |
| eoi_strobe | input | 1 | End of interrupt |
| ppr | output | 8 | Current processor priority |
| deliv_valid | output | 1 | A vector is offered |
| deliv_vec | output | 8 | Offered vector |
| eoi_out_valid | output | 1 | EOI message pulse |
| eoi_out_vec | output | 8 | Retired vector |
| eoi_out_level | output | 1 | Trigger mode of the retired vector |

## Verification
The bench uses the default parameters: 256 vectors, 32-bit words, 4-bit classes and the two-level word search. With these values, vectors in several different words and classes can be used. This covers the word-boundary ordering of the search, equal-class and strictly-greater priority compares, and level and edge reporting. The flat search variant shares the same ports and requirements. It is selected only by changing `FLAT_SEARCH`.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   localparam int unsigned VPA_MIN_LEGAL = 16;
endpackage

// File: rtl/vpa_bitmap.sv
module vpa_bitmap #(
   parameter int unsigned N = 256
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] clr_mask,
   input  logic [N-1:0] set_mask,
   output logic [N-1:0] q
);
   logic [N-1:0] q_r;

   always_ff @(posedge clk) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= (q_r & ~clr_mask) | set_mask;
   end

   assign q = q_r;
endmodule

// File: rtl/vpa_msb_find.sv
module vpa_msb_find #(
   parameter int unsigned N           = 256,
   parameter int unsigned WORD_W      = 32,
   parameter bit          FLAT_SEARCH = 1'b0,
   localparam int unsigned IDX_W      = $clog2(N),
   localparam int unsigned NUM_WORDS  = N / WORD_W,
   localparam int unsigned BIT_W      = $clog2(WORD_W)
) (
   input  logic [N-1:0]     bits,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   generate
      if (FLAT_SEARCH) begin : g_flat
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = 0; i < N; i++) begin
               if (bits[i]) begin
                  found = 1'b1;
                  idx   = IDX_W'(i);
               end
            end
         end
      end else begin : g_word
         logic [NUM_WORDS-1:0] word_nz;
         logic [BIT_W-1:0]     word_top [NUM_WORDS];

         always_comb begin
            for (int w = 0; w < NUM_WORDS; w++) begin
               word_nz[w]  = 1'b0;
               word_top[w] = '0;
               for (int b = 0; b < WORD_W; b++) begin
                  if (bits[w*WORD_W + b]) begin
                     word_nz[w]  = 1'b1;
                     word_top[w] = BIT_W'(b);
                  end
               end
            end
         end

         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int w = 0; w < NUM_WORDS; w++) begin
               if (word_nz[w]) begin
                  found = 1'b1;
                  idx   = IDX_W'(w * WORD_W) | IDX_W'(word_top[w]);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vpa_prio_calc.sv
module vpa_prio_calc #(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned CLASS_W = 4,
   localparam int unsigned LOW_W  = VEC_W - CLASS_W
) (
   input  logic             enabled,
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_found,
   input  logic [VEC_W-1:0] isr_vec,
   input  logic             irr_found,
   input  logic [VEC_W-1:0] irr_vec,
   output logic [VEC_W-1:0] ppr,
   output logic             deliver
);
   logic [VEC_W-1:0]   isr_eff;
   logic [CLASS_W-1:0] tpr_cls, isr_cls, irr_cls;
   logic [VEC_W-1:0]   irr_floor;

   always_comb begin
      isr_eff   = isr_found ? isr_vec : '0;
      tpr_cls   = tpr[VEC_W-1:LOW_W];
      isr_cls   = isr_eff[VEC_W-1:LOW_W];
      irr_cls   = irr_vec[VEC_W-1:LOW_W];
      irr_floor = {irr_cls, {LOW_W{1'b0}}};
      if (tpr_cls >= isr_cls) ppr = tpr;
      else                    ppr = {isr_cls, {LOW_W{1'b0}}};
      deliver = enabled && irr_found && (irr_floor > ppr);
   end
endmodule

// File: rtl/vec_prio_arbiter.sv
module vec_prio_arbiter #(
   parameter int unsigned NUM_VEC     = 256,
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned CLASS_W     = 4,
   parameter bit          FLAT_SEARCH = 1'b0,
   localparam int unsigned VEC_W      = $clog2(NUM_VEC),
   localparam int unsigned NUM_WORDS  = NUM_VEC / WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_en,
   input  logic             sw_en,
   input  logic             dir_eoi_en,
   input  logic             acc_valid,
   input  logic [VEC_W-1:0] acc_vec,
   input  logic             acc_level,
   output logic             acc_taken,
   input  logic             tpr_we,
   input  logic [VEC_W-1:0] tpr_wdata,
   input  logic             ack_strobe,
   input  logic             eoi_strobe,
   output logic [VEC_W-1:0] ppr,
   output logic             deliv_valid,
   output logic [VEC_W-1:0] deliv_vec,
   output logic             eoi_out_valid,
   output logic [VEC_W-1:0] eoi_out_vec,
   output logic             eoi_out_level
);
   import vpa_pkg::*;

   generate
      if (NUM_WORDS * WORD_W != NUM_VEC) begin : g_chk_words
         $error("NUM_VEC must be a multiple of WORD_W");
      end
      if ((1 << VEC_W) != NUM_VEC) begin : g_chk_pow2
         $error("NUM_VEC must be a power of two");
      end
      if (CLASS_W == 0 || CLASS_W >= VEC_W) begin : g_chk_class
         $error("CLASS_W must be between 1 and VEC_W-1");
      end
   endgenerate

   localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);

   logic               enabled;
   logic [VEC_W-1:0]   tpr_q;
   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [NUM_VEC-1:0] irr_clr, irr_set, isr_clr, isr_set, tmr_clr, tmr_set;
   logic               irr_found, isr_found;
   logic [VEC_W-1:0]   irr_top, isr_top;
   logic               acc_ok, ack_fire, eoi_fire;
   logic [NUM_VEC-1:0] acc_mask, ack_mask, eoi_mask;
   trig_e              acc_trig;
   logic               out_valid_q, out_level_q;
   logic [VEC_W-1:0]   out_vec_q;

   assign enabled  = hw_en && sw_en;
   assign acc_trig = acc_level ? TRIG_LEVEL : TRIG_EDGE;

   vpa_msb_find #(.N(NUM_VEC), .WORD_W(WORD_W), .FLAT_SEARCH(FLAT_SEARCH)) u_irr_find (
      .bits(irr_q), .found(irr_found), .idx(irr_top)
   );

   vpa_msb_find #(.N(NUM_VEC), .WORD_W(WORD_W), .FLAT_SEARCH(FLAT_SEARCH)) u_isr_find (
      .bits(isr_q), .found(isr_found), .idx(isr_top)
   );

   vpa_prio_calc #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
      .enabled  (enabled),
      .tpr      (tpr_q),
      .isr_found(isr_found),
      .isr_vec  (isr_top),
      .irr_found(irr_found),
      .irr_vec  (irr_top),
      .ppr      (ppr),
      .deliver  (deliv_valid)
   );

   assign deliv_vec = irr_top;

   always_comb begin
      acc_ok   = acc_valid && enabled;
      ack_fire = ack_strobe && deliv_valid;
      eoi_fire = eoi_strobe && isr_found;
      acc_mask = acc_ok   ? (ONE << acc_vec) : '0;
      ack_mask = ack_fire ? (ONE << irr_top) : '0;
      eoi_mask = eoi_fire ? (ONE << isr_top) : '0;
      acc_taken = acc_ok && !irr_q[acc_vec];
      irr_clr  = ack_mask;
      irr_set  = acc_mask;
      isr_clr  = eoi_mask;
      isr_set  = ack_mask;
      tmr_clr  = eoi_mask | acc_mask;
      tmr_set  = (acc_trig == TRIG_LEVEL) ? acc_mask : '0;
   end

   vpa_bitmap #(.N(NUM_VEC)) u_irr (
      .clk(clk), .rst_n(rst_n), .clr_mask(irr_clr), .set_mask(irr_set), .q(irr_q)
   );
   vpa_bitmap #(.N(NUM_VEC)) u_isr (
      .clk(clk), .rst_n(rst_n), .clr_mask(isr_clr), .set_mask(isr_set), .q(isr_q)
   );
   vpa_bitmap #(.N(NUM_VEC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr_mask(tmr_clr), .set_mask(tmr_set), .q(tmr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q       <= '0;
         out_valid_q <= 1'b0;
         out_vec_q   <= '0;
         out_level_q <= 1'b0;
      end else begin
         if (tpr_we) tpr_q <= tpr_wdata;
         out_valid_q <= eoi_fire && !dir_eoi_en;
         if (eoi_fire) begin
            out_vec_q   <= isr_top;
            out_level_q <= tmr_q[isr_top];
         end
      end
   end

   assign eoi_out_valid = out_valid_q;
   assign eoi_out_vec   = out_vec_q;
   assign eoi_out_level = out_level_q;
endmodule

// File: rtl/vpa_arbiter_chk.sv
module vpa_arbiter_chk #(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned CLASS_W   = 4,
   parameter int unsigned MIN_LEGAL = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hw_en,
   input logic             sw_en,
   input logic             dir_eoi_en,
   input logic             acc_valid,
   input logic             acc_taken,
   input logic             ack_strobe,
   input logic             eoi_strobe,
   input logic [VEC_W-1:0] ppr,
   input logic             deliv_valid,
   input logic [VEC_W-1:0] deliv_vec,
   input logic             eoi_out_valid
);
   localparam int unsigned LOW_W = VEC_W - CLASS_W;

   p_legal_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      deliv_valid |-> (deliv_vec >= VEC_W'(MIN_LEGAL)));

   p_drop_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !(hw_en && sw_en)) |-> !acc_taken);

   p_no_offer_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      deliv_valid |-> (hw_en && sw_en));

   p_ack_raises_ppr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_strobe && deliv_valid) |=>
         (ppr >= {$past(deliv_vec[VEC_W-1:LOW_W]), {LOW_W{1'b0}}}));

   p_eoi_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_out_valid |-> $past(eoi_strobe));

   p_directed_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_out_valid |-> !$past(dir_eoi_en));
endmodule

bind vec_prio_arbiter vpa_arbiter_chk #(
   .VEC_W(VEC_W), .CLASS_W(CLASS_W), .MIN_LEGAL(vpa_pkg::VPA_MIN_LEGAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en), .dir_eoi_en(dir_eoi_en),
   .acc_valid(acc_valid), .acc_taken(acc_taken), .ack_strobe(ack_strobe),
   .eoi_strobe(eoi_strobe), .ppr(ppr), .deliv_valid(deliv_valid),
   .deliv_vec(deliv_vec), .eoi_out_valid(eoi_out_valid)
);

// File: tb/vec_prio_arbiter_tb.sv
module vec_prio_arbiter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_en = 1'b0, sw_en = 1'b0, dir_eoi_en = 1'b0;
   logic       acc_valid = 1'b0, acc_level = 1'b0;
   logic [7:0] acc_vec = '0;
   logic       acc_taken;
   logic       tpr_we = 1'b0;
   logic [7:0] tpr_wdata = '0;
   logic       ack_strobe = 1'b0, eoi_strobe = 1'b0;
   logic [7:0] ppr, deliv_vec, eoi_out_vec;
   logic       deliv_valid, eoi_out_valid, eoi_out_level;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   vec_prio_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en), .dir_eoi_en(dir_eoi_en),
      .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level), .acc_taken(acc_taken),
      .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ack_strobe(ack_strobe), .eoi_strobe(eoi_strobe),
      .ppr(ppr), .deliv_valid(deliv_valid), .deliv_vec(deliv_vec),
      .eoi_out_valid(eoi_out_valid), .eoi_out_vec(eoi_out_vec), .eoi_out_level(eoi_out_level)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic accept(input logic [7:0] v, input logic lvl, input logic exp_taken, input string req);
      @(negedge clk);
      acc_valid = 1'b1; acc_vec = v; acc_level = lvl;
      #1 chk(req, "acc_taken", int'(acc_taken), int'(exp_taken));
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
   endtask

   task automatic ack();
      @(negedge clk); ack_strobe = 1'b1;
      @(negedge clk); ack_strobe = 1'b0;
      #1;
   endtask

   task automatic eoi();
      @(negedge clk); eoi_strobe = 1'b1;
      @(negedge clk); eoi_strobe = 1'b0;
      #1;
   endtask

   task automatic set_tpr(input logic [7:0] t);
      @(negedge clk); tpr_we = 1'b1; tpr_wdata = t;
      @(negedge clk); tpr_we = 1'b0;
      #1;
   endtask

   task automatic offer(input string req, input logic v, input logic [7:0] vec);
      chk(req, "deliv_valid", int'(deliv_valid), int'(v));
      if (v) chk(req, "deliv_vec", int'(deliv_vec), int'(vec));
   endtask

   task automatic t_reset();
      chk("R1", "ppr", int'(ppr), 0);
      chk("R1", "deliv_valid", int'(deliv_valid), 0);
      chk("R1", "eoi_out_valid", int'(eoi_out_valid), 0);
   endtask

   task automatic t_accept();
      accept(8'h45, 1'b0, 1'b1, "R3");
      offer("R2", 1'b1, 8'h45);
      accept(8'h45, 1'b0, 1'b0, "R3");
      accept(8'h80, 1'b1, 1'b1, "R3");
      offer("R2", 1'b1, 8'h80);
      accept(8'h7F, 1'b0, 1'b1, "R3");
      offer("R2", 1'b1, 8'h80);
   endtask

   task automatic t_ack_eoi();
      ack();
      chk("R7", "ppr", int'(ppr), 8'h80);
      offer("R7", 1'b0, 8'h00);
      eoi();
      chk("R8", "eoi_out_valid", int'(eoi_out_valid), 1);
      chk("R8", "eoi_out_vec", int'(eoi_out_vec), 8'h80);
      chk("R9", "eoi_out_level", int'(eoi_out_level), 1);
      chk("R5", "ppr", int'(ppr), 0);
      offer("R2", 1'b1, 8'h7F);
      ack();
      chk("R5", "ppr", int'(ppr), 8'h70);
      offer("R6", 1'b0, 8'h00);
      ack();
      chk("R7", "ppr ignored ack", int'(ppr), 8'h70);
      eoi();
      chk("R8", "eoi_out_vec", int'(eoi_out_vec), 8'h7F);
      chk("R9", "eoi_out_level", int'(eoi_out_level), 0);
      offer("R2", 1'b1, 8'h45);
      ack();
      eoi();
      chk("R8", "eoi_out_vec", int'(eoi_out_vec), 8'h45);
      offer("R7", 1'b0, 8'h00);
   endtask

   task automatic t_tpr();
      set_tpr(8'h35);
      chk("R5", "ppr=tpr", int'(ppr), 8'h35);
      accept(8'h3A, 1'b0, 1'b1, "R6");
      offer("R6", 1'b0, 8'h00);
      accept(8'h40, 1'b0, 1'b1, "R6");
      offer("R6", 1'b1, 8'h40);
      set_tpr(8'h40);
      offer("R6", 1'b0, 8'h00);
      set_tpr(8'h3F);
      offer("R6", 1'b1, 8'h40);
      ack();
      chk("R5", "ppr isr class", int'(ppr), 8'h40);
      set_tpr(8'h55);
      chk("R5", "ppr tpr wins", int'(ppr), 8'h55);
      set_tpr(8'h00);
      eoi();
      chk("R8", "eoi_out_vec", int'(eoi_out_vec), 8'h40);
      offer("R6", 1'b1, 8'h3A);
      ack();
      eoi();
   endtask

   task automatic t_eoi_empty();
      eoi();
      chk("R10", "eoi_out_valid", int'(eoi_out_valid), 0);
      chk("R10", "ppr", int'(ppr), 0);
      offer("R10", 1'b0, 8'h00);
   endtask

   task automatic t_directed();
      accept(8'h90, 1'b1, 1'b1, "R11");
      ack();
      chk("R11", "ppr before", int'(ppr), 8'h90);
      dir_eoi_en = 1'b1;
      eoi();
      chk("R11", "eoi_out_valid", int'(eoi_out_valid), 0);
      chk("R11", "ppr retired", int'(ppr), 0);
      dir_eoi_en = 1'b0;
   endtask

   task automatic t_level_rewrite();
      accept(8'hA0, 1'b1, 1'b1, "R9");
      accept(8'hA0, 1'b0, 1'b0, "R9");
      ack();
      eoi();
      chk("R9", "eoi_out_vec", int'(eoi_out_vec), 8'hA0);
      chk("R9", "level after edge rewrite", int'(eoi_out_level), 0);
   endtask

   task automatic t_disabled();
      sw_en = 1'b0;
      accept(8'h50, 1'b0, 1'b0, "R4");
      sw_en = 1'b1;
      #1 offer("R4", 1'b0, 8'h00);
      accept(8'h60, 1'b0, 1'b1, "R4");
      hw_en = 1'b0;
      #1 offer("R4", 1'b0, 8'h00);
      hw_en = 1'b1;
      #1 offer("R4", 1'b1, 8'h60);
      ack();
      eoi();
      chk("R4", "eoi_out_vec", int'(eoi_out_vec), 8'h60);
      offer("R4", 1'b0, 8'h00);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 t_reset();
      hw_en = 1'b1; sw_en = 1'b1;
      t_accept();
      t_ack_eoi();
      t_tpr();
      t_eoi_empty();
      t_directed();
      t_level_rewrite();
      t_disabled();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule